// File: doc/BRIEF.md
# Serial Flash Status and Write-Permission Controller

This block owns the 8-bit status register of a serial flash device and decides whether each write operation may start. A command decoder ahead of it turns completed serial transactions into single-cycle strobes. Those transactions are write enable, write disable, status write, sector erase, chip erase, page program, software reset, power-down entry, power-down exit and ID read. The decoder raises each strobe in the cycle the transaction is accepted; for software reset that is the cycle chip select rises. The decoder also supplies the sector field of the target address and the status-write data byte. An external operation timer reports either normal completion or an overrun.

For each write request the block returns a one-cycle grant or deny pulse. A granted operation sets the busy bit, and busy stays set until the timer reports completion. At completion the write-enable latch clears, and for a status write the new protection bits are committed. An overrun sets the error bit and leaves busy set; only a software reset releases it. The non-volatile bits (block-protect level and status-write lock) are ordinary registers here.

All pins are plain control and status signals, with no valid/ready handshake. Strobes are one-cycle pulses, and no back-pressure exists: a request that cannot be served is denied in the next cycle, never held.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, `pwr_down` is 0, and no grant, deny or `id_ok` pulse is present.
- R2: The status byte is laid out as follows. Bit 0 is busy (1 = busy). Bit 1 is write-enable. Bits 4:2 are the protect level. Bit 5 is the overrun error. Bit 6 always reads 0. Bit 7 is the status-write lock.
- R3: A write-enable strobe sets bit 1 and a write-disable strobe clears it, one cycle later, when the block is neither busy nor powered down. Bit 1 also clears when any granted write operation completes.
- R4: A status write, sector erase, chip erase or page program is denied, and leaves the status byte unchanged, when write-enable is 0.
- R5: The sector field selects one of eight sectors, numbered 0 to 7 from the bottom of the array. The protect levels map to protected sectors as follows:
  - level 000 protects no sector;
  - level 001 protects sector 7 only;
  - level 010 protects sectors 6 and 7;
  - level 011 protects sectors 4 to 7;
  - any level 1xx protects all eight sectors.

  A page program or sector erase aimed at a protected sector is denied. It does not set busy and leaves write-enable at 1.
- R6: A chip erase is granted only when the protect level is 000.
- R7: A status write is denied when bit 7 is 1 and `wp_n` is 0. When a granted status write completes, only bits 4:2 and 7 take the values of the corresponding data bits.
- R8: A granted request gives `wr_grant` = 1 in the cycle after the strobe, with bit 0 already set. Busy stays 1 until `op_done`, and every write request made while busy is denied.
- R9: `op_timeout` during a busy operation sets bit 5. Busy then stays 1 and `op_done` is ignored until a software reset, which clears both bits 0 and 5.
- R10: A power-down entry strobe sets `pwr_down`. While it is set, every strobe except ID read and power-down exit is ignored. Power-down exit clears `pwr_down`.
- R11: An ID read strobe yields `id_ok` = 1 in the next cycle only when not busy; this holds in power-down as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cmd_wr_en | input | 1 | Write-enable strobe |
| cmd_wr_dis | input | 1 | Write-disable strobe |
| cmd_st_wr | input | 1 | Status-write strobe |
| st_wdata | input | 8 | Status-write data byte |
| cmd_sec_ers | input | 1 | Sector-erase strobe |
| cmd_chip_ers | input | 1 | Chip-erase strobe |
| cmd_pg_prog | input | 1 | Page-program strobe |
| cmd_sw_rst | input | 1 | Software-reset strobe (at chip-select rise) |
| cmd_pd_enter | input | 1 | Power-down entry strobe |
| cmd_pd_exit | input | 1 | Power-down exit strobe |
| cmd_id_rd | input | 1 | ID-read strobe |
| op_sector | input | SECT_W | Sector field of the target address |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Timer: operation finished |
| op_timeout | input | 1 | Timer: operation exceeded its limit |
| status | output | 8 | Status byte |
| wr_grant | output | 1 | One-cycle grant for a write request |
| wr_deny | output | 1 | One-cycle deny for a write request |
| id_ok | output | 1 | One-cycle acceptance of an ID read |
| pwr_down | output | 1 | Power-down state |

## Verification
The embedded assertions check the following on every cycle:
- a grant and a deny never coincide;
- a grant implies write-enable was set and busy is now set;
- a chip-erase grant only ever follows a zero protect level;
- no grant appears during power-down;
- a set error bit persists with busy until a software reset.

The sector-to-level protection map, the masking of status-write data, the combination of the lock bit with the write-protect pin, and the timing of the write-enable clear at completion are shown only by the bench's directed scenarios. Those scenarios compare exact status bytes.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  localparam int ST_BUSY = 0;
  localparam int ST_WEN  = 1;
  localparam int ST_LVL0 = 2;
  localparam int ST_ERR  = 5;
  localparam int ST_LOCK = 7;
  localparam int LVL_W   = 3;
  // bits a status write may change: level field and lock
  localparam logic [7:0] NV_MASK = 8'h9C;
  typedef logic [LVL_W-1:0] prot_lvl_t;
endpackage

// File: rtl/fsc_prot_map.sv
module fsc_prot_map
  import flash_status_pkg::*;
#(
  parameter int SECT_W = 3
) (
  input  prot_lvl_t         lvl,
  input  logic [SECT_W-1:0] sect,
  output logic              sect_hit,
  output logic              chip_ok
);
  localparam int NSECT = 1 << SECT_W;
  localparam int TOP1  = NSECT / 8;   // one eighth
  localparam int TOP2  = NSECT / 4;   // one quarter
  localparam int TOP3  = NSECT / 2;   // one half

  logic [NSECT-1:0] mask;

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    localparam bit IN1 = (s >= NSECT - TOP1);
    localparam bit IN2 = (s >= NSECT - TOP2);
    localparam bit IN3 = (s >= NSECT - TOP3);
    always_comb begin
      mask[s] = lvl[2]
              | (IN1 && lvl[1:0] == 2'd1)
              | (IN2 && lvl[1:0] == 2'd2)
              | (IN3 && lvl[1:0] == 2'd3);
    end
  end

  assign sect_hit = mask[sect];
  assign chip_ok  = (lvl == '0);
endmodule

// File: rtl/fsc_busy_track.sv
module fsc_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  input  logic timeout,
  input  logic sw_rst,
  output logic busy,
  output logic err,
  output logic finish
);
  logic busy_q, err_q;

  assign finish = busy_q & ~err_q & done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (sw_rst && err_q) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (finish) begin
      busy_q <= 1'b0;
    end else if (busy_q && !err_q && timeout) begin
      err_q <= 1'b1;
    end else if (start) begin
      busy_q <= 1'b1;
    end
  end

  assign busy = busy_q;
  assign err  = err_q;

  // R9
  err_holds_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> busy_q);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !sw_rst) |=> err_q);
  // R8
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_en,
  input  logic              cmd_wr_dis,
  input  logic              cmd_st_wr,
  input  logic [7:0]        st_wdata,
  input  logic              cmd_sec_ers,
  input  logic              cmd_chip_ers,
  input  logic              cmd_pg_prog,
  input  logic              cmd_sw_rst,
  input  logic              cmd_pd_enter,
  input  logic              cmd_pd_exit,
  input  logic              cmd_id_rd,
  input  logic [SECT_W-1:0] op_sector,
  input  logic              wp_n,
  input  logic              op_done,
  input  logic              op_timeout,
  output logic [7:0]        status,
  output logic              wr_grant,
  output logic              wr_deny,
  output logic              id_ok,
  output logic              pwr_down
);
  logic [7:0] nv_q;        // level field and lock; other bits stay 0
  logic [7:0] pend_q;      // masked status-write data awaiting commit
  logic       pend_st_q;
  logic       wen_q, pd_q;
  logic       grant_q, deny_q, id_q;
  logic       busy, err, finish;
  logic       sect_hit, chip_ok;
  logic       any_wr, base_ok, blocked, grant_d, deny_d, live, lock_on;
  prot_lvl_t  lvl;

  assign lvl     = nv_q[ST_LVL0 +: LVL_W];
  assign lock_on = nv_q[ST_LOCK] & ~wp_n;
  assign live    = ~pd_q;

  fsc_prot_map #(.SECT_W(SECT_W)) u_map (
    .lvl      (lvl),
    .sect     (op_sector),
    .sect_hit (sect_hit),
    .chip_ok  (chip_ok)
  );

  fsc_busy_track u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (grant_d),
    .done    (op_done),
    .timeout (op_timeout),
    .sw_rst  (cmd_sw_rst & live),
    .busy    (busy),
    .err     (err),
    .finish  (finish)
  );

  always_comb begin
    any_wr  = cmd_st_wr | cmd_sec_ers | cmd_chip_ers | cmd_pg_prog;
    base_ok = live & ~busy & wen_q;
    blocked = ((cmd_sec_ers | cmd_pg_prog) & sect_hit)
            | (cmd_chip_ers & ~chip_ok)
            | (cmd_st_wr & lock_on);
    grant_d = any_wr & base_ok & ~blocked;
    deny_d  = any_wr & live & ~grant_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q      <= '0;
      pend_q    <= '0;
      pend_st_q <= 1'b0;
      wen_q     <= 1'b0;
      pd_q      <= 1'b0;
      grant_q   <= 1'b0;
      deny_q    <= 1'b0;
      id_q      <= 1'b0;
    end else begin
      grant_q <= grant_d;
      deny_q  <= deny_d;
      id_q    <= cmd_id_rd & ~busy;

      if (grant_d) begin
        pend_st_q <= cmd_st_wr;
        pend_q    <= st_wdata & NV_MASK;
      end

      if (finish) begin
        wen_q <= 1'b0;
        if (pend_st_q) nv_q <= pend_q;
        pend_st_q <= 1'b0;
      end else if (live && !busy && cmd_wr_en) begin
        wen_q <= 1'b1;
      end else if (live && !busy && cmd_wr_dis) begin
        wen_q <= 1'b0;
      end

      if (pd_q && cmd_pd_exit)                 pd_q <= 1'b0;
      else if (!pd_q && cmd_pd_enter && !busy) pd_q <= 1'b1;
    end
  end

  always_comb begin
    status          = nv_q;
    status[ST_BUSY] = busy;
    status[ST_WEN]  = wen_q;
    status[ST_ERR]  = err;
  end

  assign wr_grant = grant_q;
  assign wr_deny  = deny_q;
  assign id_ok    = id_q;
  assign pwr_down = pd_q;

  // R8
  grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_grant && wr_deny));
  // R4
  grant_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && !wen_q) |=> !wr_grant);
  // R8
  grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> status[ST_BUSY]);
  // R6
  chip_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_chip_ers && lvl != '0) |=> !wr_grant);
  // R10
  pd_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |=> !wr_grant);
endmodule

// File: tb/flash_status_ctrl_tb.sv
`timescale 1ns/1ps
module flash_status_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr_en = 0, cmd_wr_dis = 0, cmd_st_wr = 0, cmd_sec_ers = 0;
  logic cmd_chip_ers = 0, cmd_pg_prog = 0, cmd_sw_rst = 0;
  logic cmd_pd_enter = 0, cmd_pd_exit = 0, cmd_id_rd = 0;
  logic [7:0] st_wdata = 8'h00;
  logic [2:0] op_sector = 3'd0;
  logic wp_n = 1'b1, op_done = 1'b0, op_timeout = 1'b0;
  logic [7:0] status;
  logic wr_grant, wr_deny, id_ok, pwr_down;
  int checks = 0, errors = 0;

  localparam int C_WREN = 0, C_WRDI = 1, C_STWR = 2, C_SEC = 3, C_CHIP = 4,
                 C_PG = 5, C_SWR = 6, C_PDN = 7, C_PDX = 8, C_ID = 9,
                 C_DONE = 10, C_TMO = 11;

  always #2 clk = ~clk;

  flash_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_dis(cmd_wr_dis),
    .cmd_st_wr(cmd_st_wr), .st_wdata(st_wdata), .cmd_sec_ers(cmd_sec_ers),
    .cmd_chip_ers(cmd_chip_ers), .cmd_pg_prog(cmd_pg_prog),
    .cmd_sw_rst(cmd_sw_rst), .cmd_pd_enter(cmd_pd_enter),
    .cmd_pd_exit(cmd_pd_exit), .cmd_id_rd(cmd_id_rd), .op_sector(op_sector),
    .wp_n(wp_n), .op_done(op_done), .op_timeout(op_timeout),
    .status(status), .wr_grant(wr_grant), .wr_deny(wr_deny),
    .id_ok(id_ok), .pwr_down(pwr_down)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive one strobe for one cycle; return at the next falling edge
  task automatic fire(int code, logic [2:0] sec = 3'd0, logic [7:0] d = 8'h00);
    @(negedge clk);
    op_sector = sec;
    st_wdata  = d;
    case (code)
      C_WREN: cmd_wr_en    = 1'b1;
      C_WRDI: cmd_wr_dis   = 1'b1;
      C_STWR: cmd_st_wr    = 1'b1;
      C_SEC:  cmd_sec_ers  = 1'b1;
      C_CHIP: cmd_chip_ers = 1'b1;
      C_PG:   cmd_pg_prog  = 1'b1;
      C_SWR:  cmd_sw_rst   = 1'b1;
      C_PDN:  cmd_pd_enter = 1'b1;
      C_PDX:  cmd_pd_exit  = 1'b1;
      C_ID:   cmd_id_rd    = 1'b1;
      C_DONE: op_done      = 1'b1;
      default: op_timeout  = 1'b1;
    endcase
    @(negedge clk);
    {cmd_wr_en, cmd_wr_dis, cmd_st_wr, cmd_sec_ers, cmd_chip_ers, cmd_pg_prog,
     cmd_sw_rst, cmd_pd_enter, cmd_pd_exit, cmd_id_rd, op_done, op_timeout} = '0;
  endtask

  // result byte: {grant, deny}
  function automatic logic [7:0] gd();
    return {6'd0, wr_grant, wr_deny};
  endfunction

  // set protection through a granted status write
  task automatic set_nv(logic [7:0] d);
    fire(C_WREN);
    fire(C_STWR, 3'd0, d);
    fire(C_DONE);
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 outputs", {4'd0, wr_grant, wr_deny, id_ok, pwr_down}, 8'h00);
  endtask

  task automatic t_wen();
    fire(C_WREN);  chk("R3 set", status, 8'h02);
    fire(C_WRDI);  chk("R3 clear", status, 8'h00);
  endtask

  task automatic t_no_wen();
    fire(C_PG, 3'd1);
    chk("R4 deny", gd(), 8'h01);
    chk("R4 status", status, 8'h00);
  endtask

  task automatic t_busy();
    fire(C_WREN);
    fire(C_PG, 3'd1);
    chk("R8 grant", gd(), 8'h02);
    chk("R8 busy", status, 8'h03);
    fire(C_SEC, 3'd2);
    chk("R8 deny busy", gd(), 8'h01);
    fire(C_DONE);
    chk("R3 clear at done", status, 8'h00);
  endtask

  task automatic t_levels();
    set_nv(8'h67);                              // only bits 4:2,7 land
    chk("R7 mask", status, 8'h04);
    fire(C_WREN);
    fire(C_SEC, 3'd7);
    chk("R5 l1 s7 deny", gd(), 8'h01);
    chk("R5 wen kept", status, 8'h06);
    fire(C_CHIP);
    chk("R6 chip deny", gd(), 8'h01);
    fire(C_SEC, 3'd6);
    chk("R5 l1 s6 grant", gd(), 8'h02);
    fire(C_DONE);
    set_nv(8'h08);
    fire(C_WREN);
    fire(C_PG, 3'd6);  chk("R5 l2 s6 deny", gd(), 8'h01);
    fire(C_PG, 3'd5);  chk("R5 l2 s5 grant", gd(), 8'h02);
    fire(C_DONE);
    set_nv(8'h0C);
    fire(C_WREN);
    fire(C_PG, 3'd4);  chk("R5 l3 s4 deny", gd(), 8'h01);
    fire(C_PG, 3'd3);  chk("R5 l3 s3 grant", gd(), 8'h02);
    fire(C_DONE);
    set_nv(8'h14);
    chk("R2 level5", status, 8'h14);
    fire(C_WREN);
    fire(C_PG, 3'd0);  chk("R5 l5 s0 deny", gd(), 8'h01);
    fire(C_WRDI);
    set_nv(8'h00);
    chk("R5 level0", status, 8'h00);
  endtask

  task automatic t_lock();
    set_nv(8'h80);
    chk("R7 lock set", status, 8'h80);
    wp_n = 1'b0;
    fire(C_WREN);
    fire(C_STWR, 3'd0, 8'h00);
    chk("R7 lock deny", gd(), 8'h01);
    chk("R7 lock status", status, 8'h82);
    wp_n = 1'b1;
    fire(C_STWR, 3'd0, 8'h00);
    chk("R7 pin high grant", gd(), 8'h02);
    fire(C_DONE);
    chk("R7 unlocked", status, 8'h00);
  endtask

  task automatic t_timeout();
    fire(C_WREN);
    fire(C_CHIP);
    chk("R6 chip grant", gd(), 8'h02);
    fire(C_TMO);
    chk("R9 err", status, 8'h23);
    fire(C_DONE);
    chk("R9 done ignored", status, 8'h23);
    fire(C_SWR);
    chk("R9 sw reset", status, 8'h02);
    fire(C_WRDI);
  endtask

  task automatic t_pdown();
    fire(C_PDN);
    chk("R10 enter", {7'd0, pwr_down}, 8'h01);
    fire(C_WREN);
    chk("R10 ignored", status, 8'h00);
    fire(C_ID);
    chk("R11 id in pd", {7'd0, id_ok}, 8'h01);
    fire(C_PDX);
    chk("R10 exit", {7'd0, pwr_down}, 8'h00);
  endtask

  task automatic t_id_busy();
    fire(C_WREN);
    fire(C_PG, 3'd2);
    fire(C_ID);
    chk("R11 id refused", {7'd0, id_ok}, 8'h00);
    fire(C_DONE);
    chk("R11 after", status, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wen();
    t_no_wen();
    t_busy();
    t_levels();
    t_lock();
    t_timeout();
    t_pdown();
    t_id_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule